// File: doc/BRIEF.md
# NAND Bad Block Scan Engine

This block runs through a contiguous range of erase blocks on a NAND flash device. For each block it fetches the factory marker bytes from the spare area of the block's first page and decides whether the block is usable. It does not drive the flash pins itself. It hands a page address to a separate page-read engine over a simple request/response port and waits for six spare bytes to come back. Each block then gets a good or bad verdict, which is stored in an on-chip status table.

Software or a boot sequencer fills in the scan range, the number of pages in one erase block, the page size class and the bus width, and pulses start. The start block must be valid. The end block may be left open by passing a negative value or one past the device, and it is then clamped to the final block. When the walk is over, a one-cycle done strobe is raised together with an error flag and the number of bad blocks found. After that, any block's three-valued status can be read through an index port.

Top module: `nand_badblk_scan`

## Requirements
- R1: For block b the engine issues exactly one read request, and its page address is b times the pages-per-block value latched at start. Blocks are visited in ascending order from the start block to the (clamped) end block, inclusive.
- R2: When the 16-bit bus flag is set, a block is marked bad if the bitwise AND of spare byte 0 (bits 7:0 of the spare word) and spare byte 1 (bits 15:8) differs from 0xFF.
- R3: With the page size class at 0 (512-byte pages), a block is marked bad if spare byte 5 (bits 47:40) differs from 0xFF. Bytes 2 to 4 never affect the verdict.
- R4: With the page size class at 1 (2048-byte pages), a block is marked bad if spare byte 0 differs from 0xFF. The bad tests of R2 and R3/R4 are combined by OR.
- R5: An end block that is negative, or that is not below the block count, is treated as the final block (block count minus one).
- R6: A start block that is negative, or that is not below the block count, ends the scan without any read request. Done and error rise in the cycle after the start is accepted, and the bad count is 0.
- R7: Each block's status reads as 2'b00 unknown, 2'b01 good or 2'b10 bad. Reset and every accepted start set all blocks to unknown, and blocks outside the scanned range stay unknown.
- R8: Done is a single-cycle pulse at the end of every accepted scan. At that time the bad count equals the number of blocks in the range that were marked bad.
- R9: At most one read request is outstanding. The engine waits for response-valid before it issues the next request, and a response-valid that arrives while no request is outstanding changes neither the table nor the count.
- R10: A start pulse while a scan is running is ignored. The running scan keeps its range and settings.
- R11: A start block that is valid but greater than the clamped end block finishes with done, no error, no read request and a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| first_blk_i | input | IDX_W+2 | Start block, two's complement |
| last_blk_i | input | IDX_W+2 | End block, two's complement; negative means open end |
| ppb_i | input | PPB_W | Pages per erase block |
| big_page_i | input | 1 | Page size class: 0 = 512-byte, 1 = 2048-byte |
| bus16_i | input | 1 | Device on a 16-bit data bus |
| rd_req_o | output | 1 | One-cycle read request to the page reader |
| rd_page_o | output | PAGE_W | Page address of the request |
| rd_valid_i | input | 1 | Reader response valid |
| rd_spare_i | input | 48 | Spare bytes 0..5, byte k at bits 8k+7:8k |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| err_o | output | 1 | Invalid start block, valid with done |
| bad_cnt_o | output | CNT_W | Bad blocks found by the latest scan |
| q_idx_i | input | IDX_W | Block index to query |
| q_state_o | output | 2 | Status of the queried block |

## Verification
A wrong page step or a stale pages-per-block value shows up on rd_page_o at the second request of a scan, which is one response latency after the first. If a marker test uses the wrong spare byte, only certain combinations of bus width and page class expose it. The bench therefore sweeps all four combinations with spare patterns that are bad under exactly one rule, and a wrong verdict is visible on q_state_o and bad_cnt_o as soon as done arrives. Range clamping and error handling faults change the number of requests and the done/err timing within a few cycles of start.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        BLK_UNKNOWN = 2'b00,
        BLK_GOOD    = 2'b01,
        BLK_BAD     = 2'b10
    } blk_state_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } walk_state_e;

    typedef struct packed {
        logic bus16;
        logic big_page;
    } scan_mode_t;

    localparam int SPARE_BYTES = 6;
    localparam int SPARE_W     = SPARE_BYTES * 8;

    // Marker verdict: each active rule can condemn the block on its own
    function automatic logic marker_bad(input logic [SPARE_W-1:0] spare,
                                        input scan_mode_t mode);
        logic [7:0] lo0, lo1, hi5;
        lo0 = spare[7:0];
        lo1 = spare[15:8];
        hi5 = spare[47:40];
        marker_bad = (mode.bus16 && ((lo0 & lo1) != 8'hFF))
                  || (!mode.big_page && (hi5 != 8'hFF))
                  || (mode.big_page && (lo0 != 8'hFF));
    endfunction

endpackage

// File: rtl/nbs_range.sv
module nbs_range #(
    parameter int NUM_BLK = 16,
    parameter int IDX_W   = 4,
    parameter int ARG_W   = 6
) (
    input  logic [ARG_W-1:0] first_arg_i,
    input  logic [ARG_W-1:0] last_arg_i,
    output logic             first_ok_o,
    output logic             empty_o,
    output logic [IDX_W-1:0] first_idx_o,
    output logic [IDX_W-1:0] last_idx_o
);
    localparam logic [ARG_W-1:0] BLK_LIMIT = ARG_W'(NUM_BLK);
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(NUM_BLK - 1);

    logic last_open;

    always_comb begin
        first_ok_o  = !first_arg_i[ARG_W-1] && (first_arg_i < BLK_LIMIT);
        last_open   = last_arg_i[ARG_W-1] || (last_arg_i >= BLK_LIMIT);
        first_idx_o = first_arg_i[IDX_W-1:0];
        last_idx_o  = last_open ? TOP_IDX : last_arg_i[IDX_W-1:0];
        empty_o     = first_idx_o > last_idx_o;
    end
endmodule

// File: rtl/nbs_walker.sv
module nbs_walker
    import nbs_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 20,
    parameter int PPB_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              first_ok_i,
    input  logic              empty_i,
    input  logic [IDX_W-1:0]  first_idx_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [PPB_W-1:0]  ppb_i,
    input  scan_mode_t        mode_i,
    input  logic              rsp_valid_i,
    output logic              req_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic              rec_o,
    output logic              clr_o,
    output scan_mode_t        mode_o,
    output logic              done_o,
    output logic              err_o,
    output logic              busy_o
);
    walk_state_e       state;
    logic [IDX_W-1:0]  cur_q, last_q;
    logic [PAGE_W-1:0] page_q;
    logic [PPB_W-1:0]  ppb_q;
    scan_mode_t        mode_q;
    logic              err_q;

    assign clr_o     = (state == ST_IDLE) && start_i;
    assign rec_o     = (state == ST_WAIT) && rsp_valid_i;
    assign req_o     = (state == ST_ISSUE);
    assign done_o    = (state == ST_FINISH);
    assign err_o     = (state == ST_FINISH) && err_q;
    assign busy_o    = (state != ST_IDLE);
    assign page_o    = page_q;
    assign cur_idx_o = cur_q;
    assign mode_o    = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur_q  <= '0;
            last_q <= '0;
            page_q <= '0;
            ppb_q  <= '0;
            mode_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    mode_q <= mode_i;
                    ppb_q  <= ppb_i;
                    cur_q  <= first_idx_i;
                    last_q <= last_idx_i;
                    page_q <= PAGE_W'(first_idx_i) * PAGE_W'(ppb_i);
                    err_q  <= !first_ok_i;
                    state  <= (first_ok_i && !empty_i) ? ST_ISSUE : ST_FINISH;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: if (rsp_valid_i) begin
                    if (cur_q == last_q) begin
                        state <= ST_FINISH;
                    end else begin
                        cur_q  <= cur_q + 1'b1;
                        page_q <= page_q + PAGE_W'(ppb_q);
                        state  <= ST_ISSUE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    err_q <= 1'b0;
                end
            endcase
        end
    end

    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    // R1
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o && $past(rec_o)) |-> (page_o == $past(page_o) + PAGE_W'(ppb_q)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    err_early_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(clr_o));
endmodule

// File: rtl/nbs_table.sv
module nbs_table
    import nbs_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             rec_i,
    input  logic [IDX_W-1:0] rec_idx_i,
    input  logic             rec_bad_i,
    input  logic [IDX_W-1:0] q_idx_i,
    output blk_state_e       q_state_o,
    output logic [CNT_W-1:0] bad_cnt_o
);
    logic [NUM_BLK-1:0] known_q;
    logic [NUM_BLK-1:0] bad_q;
    logic [CNT_W-1:0]   cnt_q;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                known_q[g] <= 1'b0;
                bad_q[g]   <= 1'b0;
            end else if (rec_i && (rec_idx_i == IDX_W'(g))) begin
                known_q[g] <= 1'b1;
                bad_q[g]   <= rec_bad_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (rec_i && rec_bad_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        q_state_o = BLK_UNKNOWN;
        if (int'(q_idx_i) < NUM_BLK && known_q[q_idx_i]) begin
            q_state_o = bad_q[q_idx_i] ? BLK_BAD : BLK_GOOD;
        end
    end

    assign bad_cnt_o = cnt_q;

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !(rec_i && rec_bad_i)) |=> $stable(bad_cnt_o));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(bad_cnt_o) <= NUM_BLK);
endmodule

// File: rtl/nand_badblk_scan.sv
module nand_badblk_scan
    import nbs_pkg::*;
#(
    parameter  int NUM_BLK = 16,
    parameter  int PAGE_W  = 20,
    parameter  int PPB_W   = 8,
    localparam int IDX_W   = $clog2(NUM_BLK),
    localparam int ARG_W   = IDX_W + 2,
    localparam int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ARG_W-1:0]   first_blk_i,
    input  logic [ARG_W-1:0]   last_blk_i,
    input  logic [PPB_W-1:0]   ppb_i,
    input  logic               big_page_i,
    input  logic               bus16_i,
    output logic               rd_req_o,
    output logic [PAGE_W-1:0]  rd_page_o,
    input  logic               rd_valid_i,
    input  logic [SPARE_W-1:0] rd_spare_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [CNT_W-1:0]   bad_cnt_o,
    input  logic [IDX_W-1:0]   q_idx_i,
    output logic [1:0]         q_state_o
);
    logic             first_ok, empty, rec, clr;
    logic [IDX_W-1:0] first_idx, last_idx, cur_idx;
    scan_mode_t       mode_in, mode_run;
    blk_state_e       q_state;
    logic             verdict;

    assign mode_in.bus16    = bus16_i;
    assign mode_in.big_page = big_page_i;

    nbs_range #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .ARG_W(ARG_W)) u_range (
        .first_arg_i (first_blk_i),
        .last_arg_i  (last_blk_i),
        .first_ok_o  (first_ok),
        .empty_o     (empty),
        .first_idx_o (first_idx),
        .last_idx_o  (last_idx)
    );

    nbs_walker #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .PPB_W(PPB_W)) u_walker (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .first_ok_i  (first_ok),
        .empty_i     (empty),
        .first_idx_i (first_idx),
        .last_idx_i  (last_idx),
        .ppb_i       (ppb_i),
        .mode_i      (mode_in),
        .rsp_valid_i (rd_valid_i),
        .req_o       (rd_req_o),
        .page_o      (rd_page_o),
        .cur_idx_o   (cur_idx),
        .rec_o       (rec),
        .clr_o       (clr),
        .mode_o      (mode_run),
        .done_o      (done_o),
        .err_o       (err_o),
        .busy_o      (busy_o)
    );

    assign verdict = marker_bad(rd_spare_i, mode_run);

    nbs_table #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .rec_i     (rec),
        .rec_idx_i (cur_idx),
        .rec_bad_i (verdict),
        .q_idx_i   (q_idx_i),
        .q_state_o (q_state),
        .bad_cnt_o (bad_cnt_o)
    );

    assign q_state_o = q_state;

    // R11
    empty_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && empty && first_ok) |=> (done_o && !err_o && !rd_req_o));
endmodule

// File: tb/tb_nand_badblk_scan.sv
`timescale 1ns/1ps
module tb_nand_badblk_scan;
    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [5:0]  first_blk_i = '0;
    logic [5:0]  last_blk_i = '0;
    logic [7:0]  ppb_i = '0;
    logic        big_page_i = 1'b0;
    logic        bus16_i = 1'b0;
    logic        rd_req_o;
    logic [19:0] rd_page_o;
    logic        rd_valid_i = 1'b0;
    logic [47:0] rd_spare_i = '0;
    logic        busy_o, done_o, err_o;
    logic [4:0]  bad_cnt_o;
    logic [3:0]  q_idx_i = '0;
    logic [1:0]  q_state_o;

    int checks = 0;
    int fails  = 0;
    int last_cnt = 0;
    int exp_state [NB];

    always #2 clk = ~clk;

    nand_badblk_scan dut (
        .clk(clk), .rst(rst), .start_i(start_i), .first_blk_i(first_blk_i),
        .last_blk_i(last_blk_i), .ppb_i(ppb_i), .big_page_i(big_page_i),
        .bus16_i(bus16_i), .rd_req_o(rd_req_o), .rd_page_o(rd_page_o),
        .rd_valid_i(rd_valid_i), .rd_spare_i(rd_spare_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .bad_cnt_o(bad_cnt_o),
        .q_idx_i(q_idx_i), .q_state_o(q_state_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] spare_of(input int blk, input int seed);
        logic [47:0] s;
        s = '1;
        case ((blk * 7 + seed) % 6)
            1: s[7:0] = 8'h00;
            2: s[15:8] = 8'h7F;
            3: s[47:40] = 8'hF0;
            4: begin s[7:0] = 8'hFE; s[15:8] = 8'h01; end
            5: s[23:16] = 8'h00;
            default: ;
        endcase
        return s;
    endfunction

    function automatic bit exp_bad(input logic [47:0] s, input bit b16, input bit big);
        bit r;
        r = 1'b0;
        if (b16 && ((s[7:0] & s[15:8]) != 8'hFF)) r = 1'b1;
        if (!big && s[47:40] != 8'hFF) r = 1'b1;
        if (big && s[7:0] != 8'hFF) r = 1'b1;
        return r;
    endfunction

    task automatic check_table(input string tag_in);
        for (int b = 0; b < NB; b++) begin
            q_idx_i = 4'(b);
            #1;
            chk(int'(q_state_o) == exp_state[b], (exp_state[b] == 0) ? "R7" : tag_in,
                $sformatf("state of block %0d", b), q_state_o, exp_state[b]);
        end
    endtask

    task automatic run_scan(input int first, input int last, input int ppb,
                            input bit big, input bit b16, input int seed, input bit poke);
        bit    ok_first, emptyf, seen_done;
        int    lastc, blk, nreq, guard, exp_n, exp_c;
        string rtag, tag;
        ok_first = (first >= 0) && (first < NB);
        lastc    = (last < 0 || last >= NB) ? NB - 1 : last;
        emptyf   = ok_first && (first > lastc);
        exp_n    = (ok_first && !emptyf) ? (lastc - first + 1) : 0;
        rtag     = big ? "R4" : "R3";
        if (b16) rtag = {rtag, " R2"};
        exp_c = 0;
        for (int b = 0; b < NB; b++) begin
            exp_state[b] = 0;
            if (b >= first && b < first + exp_n) begin
                exp_state[b] = exp_bad(spare_of(b, seed), b16, big) ? 2 : 1;
                if (exp_state[b] == 2) exp_c++;
            end
        end
        @(negedge clk);
        first_blk_i = 6'(first);
        last_blk_i  = 6'(last);
        ppb_i       = 8'(ppb);
        big_page_i  = big;
        bus16_i     = b16;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        blk = first; nreq = 0; guard = 0; seen_done = 0;
        while (!seen_done && guard < 3000) begin
            guard++;
            if (done_o) begin
                seen_done = 1;
            end else if (rd_req_o) begin
                chk(rd_page_o == 20'(blk * ppb), "R1",
                    $sformatf("page for block %0d", blk), rd_page_o, blk * ppb);
                if (poke && nreq == 0) begin
                    first_blk_i = 6'(10);
                    start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
                for (int k = 0; k < blk % 3; k++) begin
                    chk(!rd_req_o && busy_o, "R9", "stall while waiting", rd_req_o, 0);
                    @(negedge clk);
                end
                rd_spare_i = spare_of(blk, seed);
                rd_valid_i = 1'b1;
                @(negedge clk);
                rd_valid_i = 1'b0;
                rd_spare_i = '0;
                nreq++;
                blk++;
            end else begin
                @(negedge clk);
            end
        end
        if (poke) tag = "R10";
        else if (!ok_first) tag = "R6";
        else if (emptyf) tag = "R11";
        else if (last < 0 || last >= NB) tag = "R5";
        else tag = "R1";
        chk(seen_done, "R8", "done seen", seen_done, 1);
        chk(nreq == exp_n, tag, "request count", nreq, exp_n);
        chk(err_o == !ok_first, ok_first ? "R8" : "R6", "error flag", err_o, !ok_first);
        chk(int'(bad_cnt_o) == exp_c, "R8", "bad count", bad_cnt_o, exp_c);
        @(negedge clk);
        chk(!done_o && !busy_o, "R8", "done single pulse", done_o, 0);
        last_cnt = exp_c;
        check_table(rtag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual no end, expected end of test");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !rd_req_o, "R7", "idle after reset", busy_o, 0);
        chk(bad_cnt_o == 0, "R7", "count after reset", bad_cnt_o, 0);
        for (int b = 0; b < NB; b++) exp_state[b] = 0;
        check_table("R7");

        for (int cfg = 0; cfg < 4; cfg++) begin
            bit b16, big;
            int ppb;
            b16 = cfg[1];
            big = cfg[0];
            ppb = (cfg == 3) ? 3 : (big ? 64 : 32);
            run_scan(0, -1, ppb, big, b16, cfg, 0);
            run_scan(3, 9, ppb, big, b16, cfg + 1, 0);
            run_scan(5, 16, ppb, big, b16, cfg + 2, 0);
            run_scan(15, -1, ppb, big, b16, cfg + 3, 0);
            run_scan(9, 4, ppb, big, b16, cfg, 0);
            run_scan(-1, 5, ppb, big, b16, cfg, 0);
            run_scan(16, 20, ppb, big, b16, cfg, 0);
        end
        run_scan(2, 6, 5, 1'b0, 1'b1, 4, 1);

        // stray response while idle must change nothing (R9)
        @(negedge clk);
        rd_spare_i = '0;
        rd_valid_i = 1'b1;
        @(negedge clk);
        rd_valid_i = 1'b0;
        @(negedge clk);
        chk(int'(bad_cnt_o) == last_cnt, "R9", "count after stray response", bad_cnt_o, last_cnt);
        chk(!busy_o && !rd_req_o, "R9", "idle after stray response", busy_o, 0);
        check_table("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule